// File: doc/BRIEF.md
# Converter Control and Status Register Unit

This unit sits between a 32-bit register bus and a successive-approximation converter. Software picks an input channel by writing the first channel register, and that write alone starts one conversion. The unit then runs a request/acknowledge handshake on a digital sample port that stands in for the analog core. When the sample arrives, the unit stores it, sets a completion flag and, if that conversion asked for it, raises an interrupt. A reserved all-ones channel code stops the converter. A separate calibration sequence is started from the general-control register, and its outcome is reported through a fail flag.

Reads of the result register are masked to the resolution chosen in the configuration register. A read of that register also acknowledges the completion. A configuration bit decides whether a fresh sample may replace a result that software has not read yet. A second channel register, a second result register and four plain data registers (compare value, offset, calibration value, pin control) are also decoded. Any other offset, and any unaligned offset, reads as zero and has no effect when written.

Top module: `adc_conv_regs`

## Requirements
- R1: After reset the first channel register reads 0x1F (channel code 0x1F, interrupt enable bit 7 clear), the status register (0x08), configuration (0x14), general control (0x18) and general status (0x1C) read 0, and irq and sampleReq are low.
- R2: A write to offset 0x00 with a channel code (bits [4:0]) other than 0x1F raises sampleReq from the next cycle with sampleChan equal to that code. The request holds until sampleAck.
- R3: On sampleAck during a conversion, sampleData is stored, status bit 0 sets and sampleReq drops. irq equals status bit 0 AND bit 7 of offset 0x00.
- R4: A write of channel code 0x1F to offset 0x00 drops sampleReq on the next cycle, aborts any conversion in progress and leaves status bit 0 unchanged.
- R5: A read of result offset 0x0C returns the stored sample masked by configuration bits [3:2]: 00 keeps 8 bits, 01 keeps 10 bits, 10 or 11 keep 12 bits. The upper bits read as zero.
- R6: A read of offset 0x0C clears status bit 0 and irq from the next cycle.
- R7: With configuration bit 16 set, a new sample replaces a stored result whose completion flag is still set.
- R8: With configuration bit 16 clear, a new sample that arrives while status bit 0 is set is discarded and the old result stays.
- R9: A write to offset 0x18 with bit 7 set starts calibration. sampleReq rises with sampleCal high and sampleChan 0x1F, and offset 0x18 bit 7 reads 1 until calibration ends.
- R10: On sampleAck during calibration, offset 0x18 bit 7 clears, offset 0x1C bit 1 takes the value of convFail, and status bit 0 sets, raising irq when bit 7 of offset 0x00 is set.
- R11: A write to offset 0x00 during calibration updates the register but starts no conversion, neither during calibration nor after it ends.
- R12: Unaligned offsets and offsets other than 0x00–0x28 and 0x30 (for example 0x2C, 0x34) read 0, and writes to them change nothing.
- R13: Offset 0x04 keeps bits [7] and [4:0], and offsets 0x20, 0x24, 0x28 and 0x30 keep all 32 bits of what was written. Offset 0x10 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irq | output | 1 | Conversion/calibration complete interrupt |
| sampleReq | output | 1 | Sample request to the converter |
| sampleChan | output | 5 | Channel for the current request |
| sampleCal | output | 1 | The current request is a calibration |
| sampleAck | input | 1 | Converter delivers a sample / ends calibration |
| sampleData | input | 12 | Sample value, valid with sampleAck |
| convFail | input | 1 | Calibration failed, valid with sampleAck |

## Verification
The assertions assume that sampleAck arrives only while sampleReq is high, for one cycle, and that only one bus access is made in a cycle. The bench drives its converter model only after it has seen a request, and it holds acknowledge and bus strobes for exactly one clock. The assertions also assume that read side effects happen only when busValid is high with busWrite low. The bench keeps busValid low between accesses, so an address left on the bus causes no extra read.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  localparam int NUM_AUX   = 4;
  localparam int AUX_IDX_W = $clog2(NUM_AUX);

  localparam int OFF_CH0  = 'h00;
  localparam int OFF_CH1  = 'h04;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_RES0 = 'h0C;
  localparam int OFF_RES1 = 'h10;
  localparam int OFF_CFG  = 'h14;
  localparam int OFF_GC   = 'h18;
  localparam int OFF_GS   = 'h1C;

  localparam int IE_BIT      = 7;
  localparam int CAL_BIT     = 7;
  localparam int FAIL_BIT    = 1;
  localparam int OVW_BIT     = 16;
  localparam int CFG_W       = 17;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CH0, SEL_CH1, SEL_STAT, SEL_RES0,
    SEL_RES1, SEL_CFG, SEL_GC, SEL_GS, SEL_AUX
  } regSel_t;

  typedef struct packed {
    regSel_t              sel;
    logic                 wr;
    logic                 rd;
    logic [AUX_IDX_W-1:0] auxIdx;
    logic                 startCal;
    logic                 convDone;
    logic                 calDone;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_CAL} convState_t;

  // byte offset of plain data register i: three contiguous, last one after a gap
  function automatic int auxOffset(input int i);
    return (i < 3) ? ('h20 + 4 * i) : 'h30;
  endfunction
endpackage

// File: rtl/adcr_control.sv
module adcr_control
  import adcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrCalBit,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [CH_W-1:0]   ch0Chan,
  input  logic              sampleAck,
  output strobe_t           strb,
  output logic              sampleReq,
  output logic [CH_W-1:0]   sampleChan,
  output logic              sampleCal
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [CH_W-1:0] STOP_CODE = {CH_W{1'b1}};

  convState_t state, stateNext;
  logic [WORD_W-1:0] word;
  regSel_t sel;
  logic [AUX_IDX_W-1:0] auxIdx;
  logic wrCh0, startCal, convDone, calDone;

  assign word = busAddr[ADDR_W-1:2];

  always_comb begin
    sel    = SEL_NONE;
    auxIdx = '0;
    if (busValid && busAddr[1:0] == 2'b00) begin
      case (word)
        WORD_W'(OFF_CH0  >> 2): sel = SEL_CH0;
        WORD_W'(OFF_CH1  >> 2): sel = SEL_CH1;
        WORD_W'(OFF_STAT >> 2): sel = SEL_STAT;
        WORD_W'(OFF_RES0 >> 2): sel = SEL_RES0;
        WORD_W'(OFF_RES1 >> 2): sel = SEL_RES1;
        WORD_W'(OFF_CFG  >> 2): sel = SEL_CFG;
        WORD_W'(OFF_GC   >> 2): sel = SEL_GC;
        WORD_W'(OFF_GS   >> 2): sel = SEL_GS;
        default: begin
          for (int i = 0; i < NUM_AUX; i++) begin
            if (word == WORD_W'(auxOffset(i) >> 2)) begin
              sel    = SEL_AUX;
              auxIdx = AUX_IDX_W'(i);
            end
          end
        end
      endcase
    end
  end

  assign wrCh0    = busValid && busWrite && sel == SEL_CH0;
  assign startCal = busValid && busWrite && sel == SEL_GC && wrCalBit && state != ST_CAL;
  assign convDone = state == ST_CONV && sampleAck && !startCal && !wrCh0;
  assign calDone  = state == ST_CAL && sampleAck;

  always_comb begin
    stateNext = state;
    if (startCal)
      stateNext = ST_CAL;
    else if (wrCh0 && state != ST_CAL)
      stateNext = (wrChan == STOP_CODE) ? ST_IDLE : ST_CONV;
    else if (convDone || calDone)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb          = '0;
    strb.sel      = sel;
    strb.wr       = busValid && busWrite;
    strb.rd       = busValid && !busWrite;
    strb.auxIdx   = auxIdx;
    strb.startCal = startCal;
    strb.convDone = convDone;
    strb.calDone  = calDone;
  end

  assign sampleReq  = state != ST_IDLE;
  assign sampleCal  = state == ST_CAL;
  assign sampleChan = sampleCal ? STOP_CODE : ch0Chan;

  // R2: an open conversion request persists until acknowledged or rewritten
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !sampleAck && !wrCh0 && !startCal) |=> (sampleReq && !sampleCal));

  // R4: the stop code closes the request on the next cycle
  p_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCh0 && wrChan == STOP_CODE && state != ST_CAL && !startCal) |=> !sampleReq);

  // R11: channel writes cannot pull the converter out of calibration
  p_calkeep_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAL && !sampleAck) |=> sampleCal);

  // R9: a calibration start is visible on the sample port next cycle
  p_calstart_r9: assert property (@(posedge clk) disable iff (!rstN)
    startCal |=> (sampleReq && sampleCal && sampleChan == STOP_CODE));
endmodule

// File: rtl/adcr_datapath.sv
module adcr_datapath
  import adcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int SMP_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [SMP_W-1:0]  sampleData,
  input  logic              convFail,
  output logic [DATA_W-1:0] busRdata,
  output logic [CH_W-1:0]   ch0Chan,
  output logic              irq
);
  localparam logic [SMP_W-1:0] MASK_LO  = SMP_W'((1 << (SMP_W - 4)) - 1);
  localparam logic [SMP_W-1:0] MASK_MID = SMP_W'((1 << (SMP_W - 2)) - 1);
  localparam logic [SMP_W-1:0] MASK_HI  = {SMP_W{1'b1}};

  logic              ch0Ie, ch1Ie, coco, calBit, calFail;
  logic [CH_W-1:0]   ch1Chan;
  logic [CFG_W-1:0]  cfg;
  logic [6:0]        gcLow;
  logic [SMP_W-1:0]  result, resMask;
  logic [DATA_W-1:0] auxReg [NUM_AUX];
  logic              wrHit;

  assign wrHit = strb.wr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ch0Chan <= '1;
      ch0Ie   <= 1'b0;
      ch1Chan <= '0;
      ch1Ie   <= 1'b0;
      cfg     <= '0;
      gcLow   <= '0;
    end else if (wrHit) begin
      case (strb.sel)
        SEL_CH0: begin ch0Chan <= busWdata[CH_W-1:0]; ch0Ie <= busWdata[IE_BIT]; end
        SEL_CH1: begin ch1Chan <= busWdata[CH_W-1:0]; ch1Ie <= busWdata[IE_BIT]; end
        SEL_CFG: cfg   <= busWdata[CFG_W-1:0];
        SEL_GC:  gcLow <= busWdata[6:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_AUX; g++) begin : gAux
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        auxReg[g] <= '0;
      else if (wrHit && strb.sel == SEL_AUX && strb.auxIdx == AUX_IDX_W'(g))
        auxReg[g] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calBit  <= 1'b0;
      calFail <= 1'b0;
    end else if (strb.startCal) begin
      calBit  <= 1'b1;
      calFail <= 1'b0;
    end else if (strb.calDone) begin
      calBit  <= 1'b0;
      calFail <= convFail;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      coco   <= 1'b0;
    end else begin
      if (strb.convDone && (!coco || cfg[OVW_BIT]))
        result <= sampleData;
      if (strb.convDone || strb.calDone)
        coco <= 1'b1;
      else if (strb.rd && strb.sel == SEL_RES0)
        coco <= 1'b0;
    end
  end

  assign irq = coco && ch0Ie;

  always_comb begin
    case (cfg[3:2])
      2'b00:   resMask = MASK_LO;
      2'b01:   resMask = MASK_MID;
      default: resMask = MASK_HI;
    endcase
  end

  always_comb begin
    busRdata = '0;
    case (strb.sel)
      SEL_CH0:  begin busRdata[CH_W-1:0] = ch0Chan; busRdata[IE_BIT] = ch0Ie; end
      SEL_CH1:  begin busRdata[CH_W-1:0] = ch1Chan; busRdata[IE_BIT] = ch1Ie; end
      SEL_STAT: busRdata[0] = coco;
      SEL_RES0: busRdata[SMP_W-1:0] = result & resMask;
      SEL_CFG:  busRdata[CFG_W-1:0] = cfg;
      SEL_GC:   busRdata[7:0] = {calBit, gcLow};
      SEL_GS:   busRdata[FAIL_BIT] = calFail;
      SEL_AUX:  busRdata = auxReg[strb.auxIdx];
      default:  busRdata = '0;
    endcase
  end

  // R8: an unread result survives a sample when overwrite is off
  p_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.convDone && coco && !cfg[OVW_BIT]) |=> $stable(result));

  // R7: with overwrite on, the result follows the delivered sample
  p_replace_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.convDone && cfg[OVW_BIT]) |=> (result == $past(sampleData)));

  // R10: calibration end clears the busy bit and flags completion
  p_calend_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.calDone |=> (!calBit && coco));

  // R6: a result read with no concurrent completion drops the interrupt
  p_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sel == SEL_RES0 && !strb.convDone && !strb.calDone) |=> !irq);

  // R5: 8-bit mode never exposes bits above the low byte
  p_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_RES0 && cfg[3:2] == 2'b00) |-> (busRdata[DATA_W-1:8] == '0));
endmodule

// File: rtl/adc_conv_regs.sv
module adc_conv_regs
  import adcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int SMP_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              sampleReq,
  output logic [CH_W-1:0]   sampleChan,
  output logic              sampleCal,
  input  logic              sampleAck,
  input  logic [SMP_W-1:0]  sampleData,
  input  logic              convFail
);
  strobe_t         strb;
  logic [CH_W-1:0] ch0Chan;

  adcr_control #(.ADDR_W(ADDR_W), .CH_W(CH_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busValid   (busValid),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .wrCalBit   (busWdata[CAL_BIT]),
    .wrChan     (busWdata[CH_W-1:0]),
    .ch0Chan    (ch0Chan),
    .sampleAck  (sampleAck),
    .strb       (strb),
    .sampleReq  (sampleReq),
    .sampleChan (sampleChan),
    .sampleCal  (sampleCal)
  );

  adcr_datapath #(.DATA_W(DATA_W), .CH_W(CH_W), .SMP_W(SMP_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .sampleData (sampleData),
    .convFail   (convFail),
    .busRdata   (busRdata),
    .ch0Chan    (ch0Chan),
    .irq        (irq)
  );
endmodule

// File: tb/tb_adc_conv_regs.sv
`timescale 1ns/100ps
module tb_adc_conv_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, sampleReq, sampleCal;
  logic [4:0]  sampleChan;
  logic        sampleAck = 1'b0;
  logic [11:0] sampleData = '0;
  logic        convFail = 1'b0;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_regs dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .sampleReq(sampleReq), .sampleChan(sampleChan), .sampleCal(sampleCal),
    .sampleAck(sampleAck), .sampleData(sampleData), .convFail(convFail)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic ack(input logic [11:0] d, input logic f);
    sampleAck = 1'b1; sampleData = d; convFail = f;
    @(posedge clk); @(negedge clk);
    sampleAck = 1'b0; convFail = 1'b0;
  endtask

  task automatic convert(input logic [4:0] ch, input logic ie, input logic [11:0] d);
    busWr(8'h00, {24'h0, ie, 2'b00, ch});
    check("R2 request", {31'h0, sampleReq}, 32'h1);
    ack(d, 1'b0);
    check("R3 request drops", {31'h0, sampleReq}, 32'h0);
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 sampleReq", {31'h0, sampleReq}, 32'h0);
    busRd(8'h00, v); check("R1 ch0", v, 32'h1F);
    busRd(8'h08, v); check("R1 status", v, 32'h0);
    busRd(8'h14, v); check("R1 cfg", v, 32'h0);
    busRd(8'h18, v); check("R1 gc", v, 32'h0);
    busRd(8'h1C, v); check("R1 gs", v, 32'h0);
  endtask

  task automatic tBasic();
    logic [31:0] v;
    busWr(8'h14, 32'h8);
    busWr(8'h00, 32'h83);
    check("R2 req", {31'h0, sampleReq}, 32'h1);
    check("R2 chan", {27'h0, sampleChan}, 32'h3);
    repeat (3) @(negedge clk);
    check("R2 held", {31'h0, sampleReq}, 32'h1);
    ack(12'hABC, 1'b0);
    check("R3 req low", {31'h0, sampleReq}, 32'h0);
    check("R3 irq", {31'h0, irq}, 32'h1);
    busRd(8'h08, v); check("R3 status", v, 32'h1);
    busRd(8'h0C, v); check("R5 12-bit", v, 32'hABC);
    check("R6 irq cleared", {31'h0, irq}, 32'h0);
    busRd(8'h08, v); check("R6 status cleared", v, 32'h0);
  endtask

  task automatic tMask();
    logic [31:0] v;
    busWr(8'h14, 32'h0);
    convert(5'd5, 1'b0, 12'hABC);
    busRd(8'h0C, v); check("R5 8-bit", v, 32'hBC);
    busWr(8'h14, 32'h4);
    busRd(8'h0C, v); check("R5 10-bit", v, 32'h2BC);
    busWr(8'h14, 32'hC);
    busRd(8'h0C, v); check("R5 mode 11", v, 32'hABC);
  endtask

  task automatic tOverwrite();
    logic [31:0] v;
    busWr(8'h14, 32'h8);
    convert(5'd1, 1'b0, 12'h111);
    convert(5'd1, 1'b0, 12'h222);
    busRd(8'h0C, v); check("R8 old kept", v, 32'h111);
    busWr(8'h14, 32'h10008);
    convert(5'd2, 1'b0, 12'h333);
    convert(5'd2, 1'b0, 12'h444);
    busRd(8'h0C, v); check("R7 replaced", v, 32'h444);
  endtask

  task automatic tStop();
    logic [31:0] v;
    busWr(8'h00, 32'h82);
    check("R4 started", {31'h0, sampleReq}, 32'h1);
    busWr(8'h00, 32'h9F);
    check("R4 stopped", {31'h0, sampleReq}, 32'h0);
    busRd(8'h08, v); check("R4 no result", v, 32'h0);
    convert(5'd4, 1'b0, 12'h055);
    check("R3 irq masked", {31'h0, irq}, 32'h0);
    busRd(8'h08, v); check("R3 status no ie", v, 32'h1);
    busRd(8'h0C, v);
  endtask

  task automatic tCal();
    logic [31:0] v;
    busWr(8'h00, 32'h9F);
    busWr(8'h18, 32'h80);
    check("R9 req", {31'h0, sampleReq}, 32'h1);
    check("R9 cal", {31'h0, sampleCal}, 32'h1);
    check("R9 chan", {27'h0, sampleChan}, 32'h1F);
    busRd(8'h18, v); check("R9 gc busy", v, 32'h80);
    busWr(8'h00, 32'h86);
    check("R11 still cal", {31'h0, sampleCal}, 32'h1);
    check("R11 chan", {27'h0, sampleChan}, 32'h1F);
    busRd(8'h00, v); check("R11 reg stored", v, 32'h86);
    ack(12'h000, 1'b1);
    check("R11 no conv after", {31'h0, sampleReq}, 32'h0);
    check("R10 irq", {31'h0, irq}, 32'h1);
    busRd(8'h18, v); check("R10 gc clear", v, 32'h0);
    busRd(8'h1C, v); check("R10 fail", v, 32'h2);
    busRd(8'h08, v); check("R10 status", v, 32'h1);
    busRd(8'h0C, v);
    busWr(8'h18, 32'h80);
    ack(12'h000, 1'b0);
    busRd(8'h1C, v); check("R10 pass", v, 32'h0);
    busRd(8'h0C, v);
  endtask

  task automatic tDecode();
    logic [31:0] v;
    busWr(8'h14, 32'h10008);
    busWr(8'h2C, 32'hFFFF);
    busRd(8'h2C, v); check("R12 hole", v, 32'h0);
    busWr(8'h15, 32'h0);
    busRd(8'h14, v); check("R12 unaligned write", v, 32'h10008);
    busRd(8'h16, v); check("R12 unaligned read", v, 32'h0);
    busRd(8'h34, v); check("R12 beyond", v, 32'h0);
    busWr(8'h04, 32'hFFFF_FF8A);
    busRd(8'h04, v); check("R13 ch1", v, 32'h8A);
    busWr(8'h24, 32'hDEADBEEF);
    busWr(8'h30, 32'h1234_5678);
    busRd(8'h24, v); check("R13 offset reg", v, 32'hDEADBEEF);
    busRd(8'h30, v); check("R13 pin reg", v, 32'h1234_5678);
    busRd(8'h20, v); check("R13 compare reg", v, 32'h0);
    busRd(8'h10, v); check("R13 result1", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tMask();
    tOverwrite();
    tStop();
    tCal();
    tDecode();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule